// File: doc/BRIEF.md
# Sequencer Instruction Queue with Stall Watch

This block buffers 16-bit instruction words on their way from software to a detector clocking sequencer. Software pushes words one at a time. The executing engine pulls them with a single-cycle request strobe. Each accepted request returns the oldest stored word one cycle later, so the engine runs the instructions in exactly the order they were written.

Software can poll the status outputs: a full flag, an empty flag and an occupancy count. It can also let an interrupt line tell it when at least half of the queue is free, and then write a whole batch without further checks.

Two sticky warnings show where the hand-off breaks down. A stall warning is set when the engine asks for its next instruction while nothing is queued, because back-to-back execution has then been lost; execution simply resumes once new words arrive. An overflow warning is set when software writes into a full queue, and that word is discarded. Software clears each warning by pulsing its own clear input.

Top module: `seq_instr_queue`

## Requirements
- R1: After a synchronous active-low reset, the queue reports empty=1, full=0, level=0, half_irq=1, rd_valid=0, stall=0 and wr_ovf=0.
- R2: Words leave the queue in exactly the order in which they were accepted.
- R3: An accepted request (rd_req while the queue is not empty) raises rd_valid in the next cycle, with that word on rd_data. rd_valid is low in every other cycle.
- R4: level equals accepted writes minus accepted reads and stays within 0 to DEPTH. full is 1 exactly when level equals DEPTH, and empty is 1 exactly when level is 0.
- R5: A write while full is 1 is discarded and leaves level and the stored words unchanged. It sets wr_ovf in the next cycle.
- R6: half_irq is 1 exactly when the free space (DEPTH minus level) is at least DEPTH/2.
- R7: rd_req while empty is 1 returns no word (rd_valid stays 0) and sets stall in the next cycle. stall and wr_ovf stay set until cleared.
- R8: A pulse on clr_stall or clr_ovf clears its flag in the next cycle. When a new triggering event falls in the same cycle as the clear, the flag stays set.
- R9: A write and a request in the same cycle are both judged against the state at the start of that cycle. When the queue is neither empty nor full, both take effect and level is unchanged. A write to a full queue is rejected even with a request in the same cycle. A request to an empty queue stalls even with a write in the same cycle, and that written word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WORD_W | Instruction word to store |
| rd_req | input | 1 | Engine request for the next instruction |
| clr_ovf | input | 1 | Write-one pulse that clears wr_ovf |
| clr_stall | input | 1 | Write-one pulse that clears stall |
| rd_data | output | WORD_W | Word delivered to the engine |
| rd_valid | output | 1 | rd_data carries a delivered word this cycle |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no word |
| level | output | $clog2(DEPTH)+1 | Number of stored words |
| half_irq | output | 1 | At least half of the queue is free |
| wr_ovf | output | 1 | Sticky: a write was discarded |
| stall | output | 1 | Sticky: a request found the queue empty |

## Verification
A push and a pop can fall in the same cycle. So can a flag's triggering event and the pulse that clears it. The bench fills the queue to every level from 0 to DEPTH and, at each level, drives a write and a request together. A reference model that judges both against the level at the start of the cycle predicts the result: both act, the write is rejected, or the request stalls. The bench compares level, the flags and the delivered word with that prediction. Clear pulses are driven both alone and alongside a fresh stall or overflow event, to show that the event takes priority.

// File: rtl/seq_iq_pkg.sv
// Package: shared types for the sequencer instruction queue.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_iq_pkg;

    // Occupancy change in one cycle
    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_PUSH = 2'b01,
        OCC_POP  = 2'b10,
        OCC_BOTH = 2'b11
    } occ_op_e;

    localparam int unsigned DEF_WORD_W = 16;
    localparam int unsigned DEF_DEPTH  = 512;

endpackage

// File: rtl/seq_iq_ptr_ctrl.sv
// Module: pointer and occupancy control.
// Accepts a write only when not full and a request only when not empty, both
// judged on the registered level. Tracks write/read addresses with wrap.
// Assumes: DEPTH >= 2 and even.
module seq_iq_ptr_ctrl
    import seq_iq_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_req,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              empty
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

    occ_op_e op;

    // Status decode from the registered count
    always_comb begin
        full  = (level == FULL_CNT);
        empty = (level == '0);
    end

    // Acceptance decisions for this cycle
    always_comb begin
        push = wr_en && !full;
        pop  = rd_req && !empty;
        op   = occ_op_e'({pop, push});
    end

    // Write address advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push)
            wr_ptr <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
    end

    // Read address advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (pop)
            rd_ptr <= (rd_ptr == LAST_ADDR) ? '0 : rd_ptr + 1'b1;
    end

    // Occupancy count update
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else begin
            unique case (op)
                OCC_PUSH: level <= level + 1'b1;
                OCC_POP:  level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT); // R4
    AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !(rd_req && !empty)) |=> level == $past(level) + 1'b1); // R4
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_req) |=> full && $stable(wr_ptr)); // R5
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_req && !full && !empty) |=> $stable(level)); // R9

endmodule

// File: rtl/seq_iq_storage.sv
// Module: word storage with a registered read port.
// Writes at wr_ptr on push; on pop the addressed word appears on rd_data one
// cycle later together with rd_valid.
// Assumes: push never targets an occupied slot (guaranteed by pointer control).
module seq_iq_storage
    import seq_iq_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Array write on accepted push
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wr_data;
    end

    // Registered read of the oldest word on accepted pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (pop)
            rd_data <= mem[rd_ptr];
    end

    // Delivery strobe, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= pop;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> rd_valid); // R3
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> !rd_valid); // R3

endmodule

// File: rtl/seq_iq_flags.sv
// Module: sticky warnings and the half-empty refill interrupt.
// A trigger event sets its flag; a clear pulse resets it unless an event
// arrives in the same cycle (event wins).
// Assumes: level never exceeds DEPTH.
module seq_iq_flags
    import seq_iq_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_req,
    input  logic             full,
    input  logic             empty,
    input  logic             clr_ovf,
    input  logic             clr_stall,
    input  logic [CNT_W-1:0] level,
    output logic             wr_ovf,
    output logic             stall,
    output logic             half_irq
);

    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic ovf_evt;
    logic stall_evt;

    // Event detection at the queue edges
    always_comb begin
        ovf_evt   = wr_en && full;
        stall_evt = rd_req && empty;
    end

    // Sticky overflow warning, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ovf <= 1'b0;
        else if (ovf_evt)
            wr_ovf <= 1'b1;
        else if (clr_ovf)
            wr_ovf <= 1'b0;
    end

    // Sticky stall warning, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall <= 1'b0;
        else if (stall_evt)
            stall <= 1'b1;
        else if (clr_stall)
            stall <= 1'b0;
    end

    // Refill interrupt: free space of at least half the depth
    always_comb begin
        half_irq = (level <= HALF_CNT);
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> wr_ovf); // R5
    AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> stall); // R7
    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !clr_stall) |=> stall); // R7
    AST_STALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stall && !(rd_req && empty)) |=> !stall); // R8

endmodule

// File: rtl/seq_instr_queue.sv
// Module: instruction queue between software and the clocking sequencer.
// Connects pointer control, storage and flag logic; adds no logic of its own.
// Assumes: DEPTH even and >= 2; clr_* are single-cycle write-one pulses.
module seq_instr_queue
    import seq_iq_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              clr_ovf,
    input  logic              clr_stall,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  level,
    output logic              half_irq,
    output logic              wr_ovf,
    output logic              stall
);

    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    seq_iq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_req (rd_req),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level),
        .full   (full),
        .empty  (empty)
    );

    seq_iq_storage #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    seq_iq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_req    (rd_req),
        .full      (full),
        .empty     (empty),
        .clr_ovf   (clr_ovf),
        .clr_stall (clr_stall),
        .level     (level),
        .wr_ovf    (wr_ovf),
        .stall     (stall),
        .half_irq  (half_irq)
    );

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> !rd_valid); // R7
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R4

endmodule

// File: tb/seq_instr_queue_tb_top.sv
// Bench: small-depth sweep against an arithmetic reference model.
module seq_instr_queue_tb_top;

    localparam int    W       = 16;
    localparam int    D       = 8;
    localparam int    CW      = $clog2(D) + 1;
    localparam time   CLK_PER = 10ns;
    localparam int    WD_LIM  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_req = 1'b0;
    logic          clr_ovf = 1'b0;
    logic          clr_stall = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic          full;
    logic          empty;
    logic [CW-1:0] level;
    logic          half_irq;
    logic          wr_ovf;
    logic          stall;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model
    logic [W-1:0] mq [D];
    int m_head = 0, m_tail = 0, m_lvl = 0;
    bit m_ovf = 0, m_stall = 0, m_valid = 0;
    logic [W-1:0] m_data = '0;

    always #(CLK_PER/2) clk = ~clk;

    seq_instr_queue #(.WORD_W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .clr_ovf(clr_ovf), .clr_stall(clr_stall),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
        .level(level), .half_irq(half_irq), .wr_ovf(wr_ovf), .stall(stall)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R4", "level", int'(level), m_lvl);
        chk("R4", "full", int'(full), int'(m_lvl == D));
        chk("R4", "empty", int'(empty), int'(m_lvl == 0));
        chk("R6", "half_irq", int'(half_irq), int'((D - m_lvl) >= D/2));
        chk("R5", "wr_ovf", int'(wr_ovf), int'(m_ovf));
        chk("R7", "stall", int'(stall), int'(m_stall));
        chk("R3", "rd_valid", int'(rd_valid), int'(m_valid));
        if (m_valid) chk("R2", "rd_data", int'(rd_data), int'(m_data));
    endtask

    // One clock: drive, take edge, update model from pre-edge state, compare
    task automatic step(bit we, logic [W-1:0] wd, bit rr, bit co, bit cs);
        bit push, pop;
        wr_en = we; wr_data = wd; rd_req = rr; clr_ovf = co; clr_stall = cs;
        @(posedge clk);
        #1;
        push = we && (m_lvl < D);
        pop  = rr && (m_lvl > 0);
        m_valid = pop;
        if (pop) begin
            m_data = mq[m_head];
            m_head = (m_head + 1) % D;
        end
        if (push) begin
            mq[m_tail] = wd;
            m_tail = (m_tail + 1) % D;
        end
        if (we && m_lvl == D) m_ovf = 1'b1;
        else if (co) m_ovf = 1'b0;
        if (rr && m_lvl == 0) m_stall = 1'b1;
        else if (cs) m_stall = 1'b0;
        m_lvl = m_lvl + int'(push) - int'(pop);
        wr_en = 0; rd_req = 0; clr_ovf = 0; clr_stall = 0;
        check_all();
    endtask

    function automatic logic [W-1:0] pat(int k);
        return W'((k * 16'h1357) ^ 16'hA5A5);
    endfunction

    task automatic drain();
        while (m_lvl > 0) step(0, '0, 1, 0, 0);
        step(0, '0, 0, 1, 1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIM && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIM);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "level", int'(level), 0);
        chk("R1", "half_irq", int'(half_irq), 1);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "wr_ovf", int'(wr_ovf), 0);

        // R2 R4 R6: fill to full then overflow (R5), then drain in order
        for (int k = 0; k < D; k++) step(1, pat(k), 0, 0, 0);
        step(1, 16'hDEAD, 0, 0, 0);          // R5: rejected, ovf set
        step(1, 16'hBEEF, 0, 1, 0);          // R8: event wins over clear
        step(0, '0, 0, 1, 0);                // R8: clear alone
        for (int k = 0; k < D; k++) step(0, '0, 1, 0, 0); // R2 order, R3 valid
        step(0, '0, 0, 0, 0);                // R3: valid drops

        // R7: stall on empty request, sticky, clear with event priority
        step(0, '0, 1, 0, 0);
        step(0, '0, 0, 0, 0);
        step(0, '0, 1, 0, 1);                // R8: event wins
        step(0, '0, 0, 0, 1);                // R8: cleared

        // R9: simultaneous write and request at every level
        for (int l = 0; l <= D; l++) begin
            for (int k = 0; k < l; k++) step(1, pat(100 + 10*l + k), 0, 0, 0);
            step(1, pat(500 + l), 1, 0, 0);
            step(0, '0, 0, 0, 0);
            drain();
        end

        // R2: walking-ones pattern with interleaved traffic and wrap
        for (int k = 0; k < 3*W; k++) begin
            step(1, W'(1) << (k % W), (k % 3) != 0, 0, 0);
        end
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule